// File: doc/BRIEF.md
# Global-Clock Flip-Flop Emulator

This block stands in for a flip-flop with its own clock and asynchronous controls inside a design that runs entirely on one fast global clock. The emulated flip-flop has a user clock with data input, an asynchronous load with its own load data, per-bit set and clear vectors, and an asynchronous reset to a constant. Every one of these inputs is registered on the global clock. The emulated output is then worked out from last cycle's registered values and this cycle's values, so that controls changing together in one global cycle always give the same answer.

The next-state value starts from the held output, or from the data registered in the previous global cycle when a user-clock edge is seen. Two update passes follow. The first uses only the registered (previous) control values and the second uses only the current ones. Each pass applies load, then set/clear, then reset. The effect is a negative hold time: a control that was active in the last cycle still acts once more. Parameters pick the width, the clock and control polarities, which controls exist, the power-up value and the reset value. The active-low `rst_n` returns every internal register to its power-up state.

Top module: `ffemu_top`

## Requirements
- R1: After `rst_n` is released the output equals INIT_VAL (default 8'h5A) while all controls are inactive. A user clock that is already at its active level in the first cycle causes no edge.
- R2: A user-clock edge (low then high, default polarity) makes `q` equal to the `d` value present in the global cycle before the edge. Between edges `q` holds.
- R3: While the load control is active, and no set, clear or reset is active, `q` equals the current load data.
- R4: In the cycle the load control falls, `q` equals the load data of the previous cycle, not the current one.
- R5: Each set bit forces its `q` bit to 1 and each clear bit forces it to 0. Clear wins when both are active, unless reset is active.
- R6: A clear bit that falls in the same cycle a set bit rises leaves that `q` bit at 1.
- R7: While reset is active, `q` equals RST_VAL (default 8'hC3), whatever load, set, clear or data are doing.
- R8: When reset falls in the same cycle as a user-clock edge, `q` shows RST_VAL in that cycle and keeps it until the next edge or control.
- R9: Within a pass, load is applied before set/clear: with load and set both active, `q` is the load data OR the set bits.
- R10: With no edge and no control active in the current or previous cycle, `q` keeps its value from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global clock on which everything is sampled |
| rst_n | input | 1 | Active-low return to power-up state |
| uclk | input | 1 | Emulated flip-flop clock |
| d | input | W | Clocked data |
| ld | input | 1 | Asynchronous load control |
| ld_data | input | W | Asynchronous load data |
| set_v | input | W | Per-bit set |
| clr_v | input | W | Per-bit clear |
| arst | input | 1 | Asynchronous reset to RST_VAL |
| q | output | W | Emulated flip-flop output |

## Verification
The hardest situations to reach are those where two inputs change in the same global cycle. Examples are a falling load together with new load data, a falling clear next to a rising set, and a reset release that lands on a user-clock edge. Random stimulus seldom lines these up. The bench therefore drives each pairing as a directed two-cycle sequence with literal expected values. It then runs a long stretch of sparse random stimulus, compared cycle by cycle against a behavioural model.

// File: rtl/ffemu_pkg.sv
package ffemu_pkg;

  function automatic logic act_hi(input logic v, input bit pol);
    return pol ? v : ~v;
  endfunction

  function automatic logic [63:0] load_sel(input logic [63:0] cur, input logic [63:0] ldv,
                                           input logic en);
    return en ? ldv : cur;
  endfunction

  function automatic logic [63:0] sr_apply(input logic [63:0] cur, input logic [63:0] s,
                                           input logic [63:0] c);
    return (cur | s) & ~c;
  endfunction

endpackage

// File: rtl/ffemu_sreg.sv
module ffemu_sreg #(
  parameter int W = 8,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         gclk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) dout <= INIT;
    else        dout <= din;
  end
endmodule

// File: rtl/ffemu_edge.sv
module ffemu_edge #(
  parameter bit POL = 1'b1
) (
  input  logic gclk,
  input  logic rst_n,
  input  logic uclk,
  output logic edge_o
);
  logic clk_s;
  ffemu_sreg #(.W(1), .INIT(POL)) u_clk_s (
    .gclk(gclk), .rst_n(rst_n), .din(uclk), .dout(clk_s)
  );
  generate
    if (POL) begin : g_rise
      assign edge_o = ~clk_s & uclk;
    end else begin : g_fall
      assign edge_o = clk_s & ~uclk;
    end
  endgenerate
endmodule

// File: rtl/ffemu_pass.sv
module ffemu_pass
  import ffemu_pkg::*;
#(
  parameter int W = 8,
  parameter bit HAS_LD = 1'b1,
  parameter bit HAS_SR = 1'b1,
  parameter bit HAS_RST = 1'b1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic [W-1:0] qin,
  input  logic         ld_a,
  input  logic [W-1:0] ldv,
  input  logic [W-1:0] set_a,
  input  logic [W-1:0] clr_a,
  input  logic         rst_a,
  output logic [W-1:0] qout
);
  logic [W-1:0] after_ld, after_sr;
  logic [63:0]  ld_w, sr_w;

  generate
    if (HAS_LD) begin : g_ld
      assign ld_w     = load_sel(64'(qin), 64'(ldv), ld_a);
      assign after_ld = ld_w[W-1:0];
    end else begin : g_no_ld
      assign ld_w     = '0;
      assign after_ld = qin;
    end
    if (HAS_SR) begin : g_sr
      assign sr_w     = sr_apply(64'(after_ld), 64'(set_a), 64'(clr_a));
      assign after_sr = sr_w[W-1:0];
    end else begin : g_no_sr
      assign sr_w     = '0;
      assign after_sr = after_ld;
    end
    if (HAS_RST) begin : g_rst
      assign qout = rst_a ? RST_VAL : after_sr;
    end else begin : g_no_rst
      assign qout = after_sr;
    end
  endgenerate

  logic unused_ok;
  assign unused_ok = ^{ld_w, sr_w, ld_a, ldv, set_a, clr_a, rst_a};
endmodule

// File: rtl/ffemu_top.sv
module ffemu_top
  import ffemu_pkg::*;
#(
  parameter int W = 8,
  parameter bit HAS_CLK = 1'b1,
  parameter bit CLK_POL = 1'b1,
  parameter bit HAS_LD = 1'b1,
  parameter bit LD_POL = 1'b1,
  parameter bit HAS_SR = 1'b1,
  parameter bit SET_POL = 1'b1,
  parameter bit CLR_POL = 1'b1,
  parameter bit HAS_RST = 1'b1,
  parameter bit RST_POL = 1'b1,
  parameter logic [W-1:0] INIT_VAL = 8'h5A,
  parameter logic [W-1:0] RST_VAL = 8'hC3
) (
  input  logic         gclk,
  input  logic         rst_n,
  input  logic         uclk,
  input  logic [W-1:0] d,
  input  logic         ld,
  input  logic [W-1:0] ld_data,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  input  logic         arst,
  output logic [W-1:0] q
);
  localparam int NPASS = 2;

  // active-high current values of controls
  logic         ld_a, rst_a;
  logic [W-1:0] set_a, clr_a;
  // registered (previous-cycle) values
  logic         ld_s, rst_s;
  logic [W-1:0] set_s, clr_s, ldv_s, d_s, q_hold;
  // internal events
  logic         uclk_edge;
  logic [W-1:0] base_q;

  assign ld_a  = HAS_LD  ? act_hi(ld, LD_POL)   : 1'b0;
  assign rst_a = HAS_RST ? act_hi(arst, RST_POL) : 1'b0;
  assign set_a = HAS_SR  ? (SET_POL ? set_v : ~set_v) : '0;
  assign clr_a = HAS_SR  ? (CLR_POL ? clr_v : ~clr_v) : '0;

  ffemu_sreg #(.W(W), .INIT(INIT_VAL)) u_qhold (
    .gclk(gclk), .rst_n(rst_n), .din(q), .dout(q_hold)
  );

  generate
    if (HAS_CLK) begin : g_clk
      ffemu_edge #(.POL(CLK_POL)) u_edge (
        .gclk(gclk), .rst_n(rst_n), .uclk(uclk), .edge_o(uclk_edge)
      );
      ffemu_sreg #(.W(W), .INIT('0)) u_d_s (
        .gclk(gclk), .rst_n(rst_n), .din(d), .dout(d_s)
      );
    end else begin : g_no_clk
      assign uclk_edge = 1'b0;
      assign d_s       = '0;
    end

    if (HAS_LD) begin : g_ld
      ffemu_sreg #(.W(1), .INIT(1'b0)) u_ld_s (
        .gclk(gclk), .rst_n(rst_n), .din(ld_a), .dout(ld_s)
      );
      ffemu_sreg #(.W(W), .INIT('0)) u_ldv_s (
        .gclk(gclk), .rst_n(rst_n), .din(ld_data), .dout(ldv_s)
      );
    end else begin : g_no_ld
      assign ld_s  = 1'b0;
      assign ldv_s = '0;
    end

    if (HAS_SR) begin : g_sr
      ffemu_sreg #(.W(W), .INIT('0)) u_set_s (
        .gclk(gclk), .rst_n(rst_n), .din(set_a), .dout(set_s)
      );
      ffemu_sreg #(.W(W), .INIT('0)) u_clr_s (
        .gclk(gclk), .rst_n(rst_n), .din(clr_a), .dout(clr_s)
      );
    end else begin : g_no_sr
      assign set_s = '0;
      assign clr_s = '0;
    end

    if (HAS_RST) begin : g_rst
      ffemu_sreg #(.W(1), .INIT(1'b0)) u_rst_s (
        .gclk(gclk), .rst_n(rst_n), .din(rst_a), .dout(rst_s)
      );
    end else begin : g_no_rst
      assign rst_s = 1'b0;
    end
  endgenerate

  assign base_q = uclk_edge ? d_s : q_hold;

  // pass 0 uses sampled values, pass 1 current values
  logic [NPASS-1:0]        ph_ld, ph_rst;
  logic [NPASS-1:0][W-1:0] ph_ldv, ph_set, ph_clr;
  logic [NPASS:0][W-1:0]   chain;

  assign ph_ld  = {ld_a, ld_s};
  assign ph_rst = {rst_a, rst_s};
  assign ph_ldv = {ld_data, ldv_s};
  assign ph_set = {set_a, set_s};
  assign ph_clr = {clr_a, clr_s};
  assign chain[0] = base_q;

  generate
    for (genvar p = 0; p < NPASS; p++) begin : g_pass
      ffemu_pass #(
        .W(W), .HAS_LD(HAS_LD), .HAS_SR(HAS_SR), .HAS_RST(HAS_RST), .RST_VAL(RST_VAL)
      ) u_pass (
        .qin(chain[p]), .ld_a(ph_ld[p]), .ldv(ph_ldv[p]),
        .set_a(ph_set[p]), .clr_a(ph_clr[p]), .rst_a(ph_rst[p]),
        .qout(chain[p+1])
      );
    end
  endgenerate

  assign q = chain[NPASS];
endmodule

// File: rtl/ffemu_chk.sv
module ffemu_chk #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input logic         gclk,
  input logic         rst_n,
  input logic         uclk_edge,
  input logic         ld_a,
  input logic [W-1:0] ld_data,
  input logic [W-1:0] set_a,
  input logic [W-1:0] clr_a,
  input logic         rst_a,
  input logic [W-1:0] q
);
  logic quiet;
  assign quiet = !ld_a && (set_a == '0) && (clr_a == '0) && !rst_a;

  a_r1_no_first_edge: assert property (@(posedge gclk) disable iff (!rst_n)
    $rose(rst_n) |-> !uclk_edge);

  a_r3_load_follows: assert property (@(posedge gclk) disable iff (!rst_n)
    (ld_a && set_a == '0 && clr_a == '0 && !rst_a) |-> q == ld_data);

  a_r5_clear_wins: assert property (@(posedge gclk) disable iff (!rst_n)
    !rst_a |-> (q & clr_a) == '0);

  a_r6_set_visible: assert property (@(posedge gclk) disable iff (!rst_n)
    !rst_a |-> (q & set_a & ~clr_a) == (set_a & ~clr_a));

  a_r7_reset_forces: assert property (@(posedge gclk) disable iff (!rst_n)
    rst_a |-> q == RST_VAL);

  a_r8_reset_lingers: assert property (@(posedge gclk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_a) && quiet) |-> q == RST_VAL);

  a_r10_hold: assert property (@(posedge gclk) disable iff (!rst_n)
    ($past(rst_n) && $past(quiet) && quiet && !uclk_edge) |-> q == $past(q));
endmodule

bind ffemu_top ffemu_chk #(.W(W), .RST_VAL(RST_VAL)) u_chk (
  .gclk(gclk), .rst_n(rst_n), .uclk_edge(uclk_edge), .ld_a(ld_a),
  .ld_data(ld_data), .set_a(set_a), .clr_a(clr_a), .rst_a(rst_a), .q(q)
);

// File: tb/sim_ffemu_top.sv
module sim_ffemu_top;
  localparam int W = 8;
  localparam logic [W-1:0] INITV = 8'h5A;
  localparam logic [W-1:0] RSTV  = 8'hC3;

  logic gclk = 1'b0;
  logic rst_n = 1'b0;
  logic uclk = 1'b1, ld = 1'b0, arst = 1'b0;
  logic [W-1:0] d = '0, ld_data = '0, set_v = '0, clr_v = '0;
  logic [W-1:0] q;

  int n_chk = 0, n_fail = 0;

  // model history (values seen in the previous global cycle)
  logic p_uclk = 1'b1, p_ld = 1'b0, p_rst = 1'b0;
  logic [W-1:0] p_d = '0, p_ldv = '0, p_set = '0, p_clr = '0, p_q = INITV;

  always #4 gclk = ~gclk;

  ffemu_top u0 (
    .gclk(gclk), .rst_n(rst_n), .uclk(uclk), .d(d), .ld(ld), .ld_data(ld_data),
    .set_v(set_v), .clr_v(clr_v), .arst(arst), .q(q)
  );

  function automatic logic [W-1:0] model_q();
    logic [W-1:0] r;
    for (int b = 0; b < W; b++) begin
      int v;
      v = (!p_uclk && uclk) ? int'(p_d[b]) : int'(p_q[b]);
      // old controls act once more, then current ones
      if (p_ld) v = p_ldv[b];
      if (p_set[b]) v = 1;
      if (p_clr[b]) v = 0;
      if (p_rst) v = RSTV[b];
      if (ld) v = ld_data[b];
      if (set_v[b]) v = 1;
      if (clr_v[b]) v = 0;
      if (arst) v = RSTV[b];
      r[b] = v[0];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp);
    n_chk++;
    if (q !== exp) begin
      n_fail++;
      $display("FAIL %s: q=%h expected=%h at %0t", req, q, exp, $time);
    end
  endtask

  // drive, compare against model and optional literal, then advance one cycle
  task automatic step(input logic c, input logic [W-1:0] dd, input logic l,
                      input logic [W-1:0] lv, input logic [W-1:0] s,
                      input logic [W-1:0] cl, input logic r,
                      input string req, input bit use_lit, input logic [W-1:0] lit);
    logic [W-1:0] e;
    uclk = c; d = dd; ld = l; ld_data = lv; set_v = s; clr_v = cl; arst = r;
    #2;
    e = model_q();
    check(req, e);
    if (use_lit) check(req, lit);
    @(posedge gclk);
    p_uclk = uclk; p_d = d; p_ld = ld; p_ldv = ld_data;
    p_set = set_v; p_clr = clr_v; p_rst = arst; p_q = e;
    @(negedge gclk);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: q=%h expected=done", q);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge gclk);
    rst_n = 1'b1;
    // R1: user clock already high, nothing active
    step(1, 8'h00, 0, 8'h00, 8'h00, 8'h00, 0, "R1", 1, INITV);
    step(1, 8'h00, 0, 8'h00, 8'h00, 8'h00, 0, "R10", 1, INITV);
    // R2: edge takes previous-cycle d
    step(0, 8'h3C, 0, 8'h00, 8'h00, 8'h00, 0, "R2", 1, INITV);
    step(1, 8'hFF, 0, 8'h00, 8'h00, 8'h00, 0, "R2", 1, 8'h3C);
    step(1, 8'h00, 0, 8'h00, 8'h00, 8'h00, 0, "R2", 1, 8'h3C);
    // R3/R4: load follows current data, falling load keeps old data
    step(1, 8'h00, 1, 8'h11, 8'h00, 8'h00, 0, "R3", 1, 8'h11);
    step(1, 8'h00, 1, 8'h22, 8'h00, 8'h00, 0, "R3", 1, 8'h22);
    step(1, 8'h00, 0, 8'h99, 8'h00, 8'h00, 0, "R4", 1, 8'h22);
    step(1, 8'h00, 0, 8'h99, 8'h00, 8'h00, 0, "R10", 1, 8'h22);
    // R5: set and clear, clear wins
    step(1, 8'h00, 0, 8'h00, 8'h0F, 8'hF0, 0, "R5", 1, 8'h0F);
    step(1, 8'h00, 0, 8'h00, 8'h01, 8'h01, 0, "R5", 1, 8'h0E);
    // R6: clear falls while set rises
    step(1, 8'h00, 0, 8'h00, 8'h00, 8'hFF, 0, "R6", 1, 8'h00);
    step(1, 8'h00, 0, 8'h00, 8'h81, 8'h00, 0, "R6", 1, 8'h81);
    // R9: load then set
    step(1, 8'h00, 1, 8'h00, 8'h0F, 8'h00, 0, "R9", 1, 8'h0F);
    step(1, 8'h00, 0, 8'h00, 8'h00, 8'h00, 0, "R4", 1, 8'h0F);
    // R7: reset over everything
    step(1, 8'hAA, 1, 8'hFF, 8'hFF, 8'h00, 1, "R7", 1, RSTV);
    step(0, 8'hAA, 0, 8'h00, 8'h00, 8'h00, 1, "R7", 1, RSTV);
    // R8: reset release on a clock edge
    step(1, 8'h55, 0, 8'h00, 8'h00, 8'h00, 0, "R8", 1, RSTV);
    step(1, 8'h55, 0, 8'h00, 8'h00, 8'h00, 0, "R8", 1, RSTV);
    step(0, 8'h55, 0, 8'h00, 8'h00, 8'h00, 0, "R2", 1, RSTV);
    step(1, 8'h00, 0, 8'h00, 8'h00, 8'h00, 0, "R2", 1, 8'h55);
    // random sparse stimulus against model
    for (int i = 0; i < 2000; i++) begin
      logic c, l, r;
      logic [W-1:0] s, cl;
      c  = ($urandom % 3) == 0 ? ~uclk : uclk;
      l  = ($urandom % 5) == 0;
      r  = ($urandom % 9) == 0;
      s  = ($urandom % 4) == 0 ? W'($urandom) & W'($urandom) : '0;
      cl = ($urandom % 4) == 0 ? W'($urandom) & W'($urandom) : '0;
      step(c, W'($urandom), l, W'($urandom), s, cl, r, "R10", 0, '0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule